// File: doc/BRIEF.md
# Threshold Offset Register Sequencer

This block stores the two threshold offsets that a FIFO's almost-empty and almost-full flags compare against. Each offset is split across a byte-wide low register and a narrow high register that carries only the address bits above bit 7. Software or a neighbouring controller writes them through the FIFO's own write data bus and reads them back through its read data bus. The block acts only while the FIFO is in programmable-threshold mode and the shared active-low load pin is held low.

No register address is supplied. The write side and the read side each keep a 2-bit position that steps through empty-low, empty-high, full-low and full-high on every qualifying clock edge, then wraps. When load is released after a partial update, the position stays where it stopped, and the next load-qualified edge continues from there. The full offset is used in the write-clock domain and is presented there directly. The empty offset is used by read-side flag logic, so it passes through a synchronizer into the read-clock domain. Readback also uses synchronized copies. The offsets are assumed static while normal FIFO traffic flows.

Top module: `ofs_seq_port`

## Requirements
- R1: While rst_n is low, empty_ofs and full_ofs read 7, rb_data reads 0 and rb_sel reads 0. Both sequence positions return to empty-low, so the first write and the first readback after reset address empty-low.
- R2: A write-clock rising edge with prog_mode=1, load_n=0 and wen1_n=0 writes one register. Successive such edges write, in order, empty-low, empty-high, full-low and full-high.
- R3: After full-high, the next qualifying write edge writes empty-low again.
- R4: A write edge with load_n=1 or wen1_n=1 writes nothing and does not move the write position. The next qualifying edge continues with the following register.
- R5: A low-register write puts wr_data[7:0] into offset bits 7:0. A high-register write puts wr_data[ADDR_W-9:0] into offset bits ADDR_W-1:8. Every other wr_data bit is ignored. With the default ADDR_W=11, the high field is 3 bits.
- R6: A read-clock rising edge with prog_mode=1, load_n=0, ren1_n=0 and ren2_n=0 loads rb_data with the register at the read position, zero-extended, and steps that position in the same four-step order, wrapping after full-high.
- R7: A read edge without all of load_n, ren1_n and ren2_n low leaves the read position and rb_data unchanged. A partial readback resumes from the next register.
- R8: With prog_mode=0, no write or readback edge changes any offset or either position.
- R9: full_ofs shows a written value after the write edge. empty_ofs shows it on the second read-clock edge after the write edge, not on the first.
- R10: rb_sel is set by a readback edge. It is cleared by a read edge that has both read enables low but is not a readback. It holds on any other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | FIFO configured for programmable thresholds |
| load_n | input | 1 | Active-low load select shared with the FIFO |
| wen1_n | input | 1 | Active-low write enable |
| wr_data | input | DATA_W | FIFO write data bus |
| ren1_n | input | 1 | Active-low read enable 1 |
| ren2_n | input | 1 | Active-low read enable 2 |
| empty_ofs | output | ADDR_W | Empty threshold offset, read-clock domain |
| full_ofs | output | ADDR_W | Full threshold offset, write-clock domain |
| rb_data | output | DATA_W | Readback value for the FIFO output mux |
| rb_sel | output | 1 | Output mux should present rb_data |

## Verification
The bound checker watches several properties on every edge. Each qualifying write or readback edge must advance its position by exactly one, modulo four. Any other edge must leave the position, full_ofs and rb_data untouched. rb_sel must follow its set, clear and hold rule, and no write may fire outside programmable mode. Some behaviour cannot be seen from these properties and is shown only by the bench's scenarios: which register a given position maps to, how wr_data bits are sliced into the low and high fields, zero-filling on readback, the two-edge delay of empty_ofs, and the values after a mid-run reset.

// File: rtl/ofs_seq_pkg.sv
`timescale 1ns/1ps
package ofs_seq_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } ofs_slot_e;

  localparam int LO_W        = 8;
  localparam int DEFAULT_OFS = 7;

  // Step to the next register in the fixed rotation.
  function automatic ofs_slot_e slot_next(input ofs_slot_e s);
    logic [1:0] raw;
    raw = 2'(s + 2'd1);
    return ofs_slot_e'(raw);
  endfunction

endpackage

// File: rtl/ofs_sync.sv
`timescale 1ns/1ps
module ofs_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ofs_wr_bank.sv
`timescale 1ns/1ps
module ofs_wr_bank
  import ofs_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DATA_W-1:0] data,
  output ofs_slot_e         slot,
  output logic [ADDR_W-1:0] e_ofs,
  output logic [ADDR_W-1:0] f_ofs
);
  localparam int HI_W = ADDR_W - LO_W;

  logic [LO_W-1:0] e_lo, f_lo;
  logic [HI_W-1:0] e_hi, f_hi;
  logic            wr_unused_bits;

  assign wr_unused_bits = ^data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= SLOT_EMPTY_LO;
      e_lo <= LO_W'(DEFAULT_OFS);
      f_lo <= LO_W'(DEFAULT_OFS);
      e_hi <= '0;
      f_hi <= '0;
    end else if (fire) begin
      unique case (slot)
        SLOT_EMPTY_LO: e_lo <= data[LO_W-1:0];
        SLOT_EMPTY_HI: e_hi <= data[HI_W-1:0];
        SLOT_FULL_LO:  f_lo <= data[LO_W-1:0];
        SLOT_FULL_HI:  f_hi <= data[HI_W-1:0];
      endcase
      slot <= slot_next(slot);
    end
  end

  assign e_ofs = {e_hi, e_lo};
  assign f_ofs = {f_hi, f_lo};
endmodule

// File: rtl/ofs_rd_port.sv
`timescale 1ns/1ps
module ofs_rd_port
  import ofs_seq_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              rd_any,
  input  logic [ADDR_W-1:0] e_ofs,
  input  logic [ADDR_W-1:0] f_ofs,
  output ofs_slot_e         slot,
  output logic [DATA_W-1:0] rb_data,
  output logic              rb_sel
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    unique case (slot)
      SLOT_EMPTY_LO: pick = DATA_W'(e_ofs[LO_W-1:0]);
      SLOT_EMPTY_HI: pick = DATA_W'(e_ofs[ADDR_W-1:LO_W]);
      SLOT_FULL_LO:  pick = DATA_W'(f_ofs[LO_W-1:0]);
      SLOT_FULL_HI:  pick = DATA_W'(f_ofs[ADDR_W-1:LO_W]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot    <= SLOT_EMPTY_LO;
      rb_data <= '0;
      rb_sel  <= 1'b0;
    end else begin
      if (fire) begin
        rb_data <= pick;
        slot    <= slot_next(slot);
      end
      if (rd_any) rb_sel <= fire;
    end
  end
endmodule

// File: rtl/ofs_seq_port.sv
`timescale 1ns/1ps
module ofs_seq_port
  import ofs_seq_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              load_n,
  input  logic              wen1_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ren1_n,
  input  logic              ren2_n,
  output logic [ADDR_W-1:0] empty_ofs,
  output logic [ADDR_W-1:0] full_ofs,
  output logic [DATA_W-1:0] rb_data,
  output logic              rb_sel
);
  localparam logic [ADDR_W-1:0] OFS_RST = ADDR_W'(DEFAULT_OFS);

  // Named events, visible to the bound checker.
  logic              wr_fire, rd_fire, rd_any;
  ofs_slot_e         wr_slot, rd_slot;
  logic [ADDR_W-1:0] e_ofs_w, f_ofs_w, e_ofs_r, f_ofs_r;

  assign wr_fire = prog_mode & ~load_n & ~wen1_n;
  assign rd_any  = ~ren1_n & ~ren2_n;
  assign rd_fire = prog_mode & ~load_n & rd_any;

  ofs_wr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(wr_clk), .rst_n(rst_n), .fire(wr_fire), .data(wr_data),
    .slot(wr_slot), .e_ofs(e_ofs_w), .f_ofs(f_ofs_w)
  );

  ofs_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL(OFS_RST)) u_sync_e (
    .clk(rd_clk), .rst_n(rst_n), .din(e_ofs_w), .dout(e_ofs_r)
  );

  ofs_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL(OFS_RST)) u_sync_f (
    .clk(rd_clk), .rst_n(rst_n), .din(f_ofs_w), .dout(f_ofs_r)
  );

  ofs_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .fire(rd_fire), .rd_any(rd_any),
    .e_ofs(e_ofs_r), .f_ofs(f_ofs_r), .slot(rd_slot),
    .rb_data(rb_data), .rb_sel(rb_sel)
  );

  assign empty_ofs = e_ofs_r;
  assign full_ofs  = f_ofs_w;
endmodule

// File: rtl/ofs_seq_port_chk.sv
`timescale 1ns/1ps
module ofs_seq_port_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              prog_mode,
  input logic              wr_fire,
  input logic              rd_fire,
  input logic              rd_any,
  input logic [1:0]        wr_slot,
  input logic [1:0]        rd_slot,
  input logic [ADDR_W-1:0] full_ofs,
  input logic [DATA_W-1:0] rb_data,
  input logic              rb_sel
);
  // R2 and R3: a write steps the position by one, modulo four.
  assert_wr_step_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_fire |=> wr_slot == 2'($past(wr_slot) + 2'd1));
  // R4: an edge without a write leaves the position alone.
  assert_wr_hold_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_fire |=> $stable(wr_slot));
  // R4: an edge without a write leaves the full offset alone.
  assert_full_hold_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_fire |=> $stable(full_ofs));
  // R8: no write outside programmable mode.
  assert_mode_gate_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !prog_mode |-> !wr_fire);
  // R6: a readback steps the read position by one, modulo four.
  assert_rd_step_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_fire |=> rd_slot == 2'($past(rd_slot) + 2'd1));
  // R7: an edge without a readback holds the position and the data.
  assert_rd_hold_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_slot) && $stable(rb_data));
  // R10: rb_sel is set, cleared or held.
  assert_sel_set_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_fire |=> rb_sel);
  assert_sel_clr_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_any && !rd_fire) |=> !rb_sel);
  assert_sel_hold_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_any |=> $stable(rb_sel));
endmodule

bind ofs_seq_port ofs_seq_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .prog_mode(prog_mode),
  .wr_fire(wr_fire), .rd_fire(rd_fire), .rd_any(rd_any),
  .wr_slot(wr_slot), .rd_slot(rd_slot), .full_ofs(full_ofs),
  .rb_data(rb_data), .rb_sel(rb_sel)
);

// File: tb/ofs_seq_port_test.sv
`timescale 1ns/1ps
module ofs_seq_port_test;
  logic clk = 1'b0;
  logic rst_n, prog_mode, load_n, wen1_n, ren1_n, ren2_n;
  logic [8:0]  wr_data;
  logic [10:0] empty_ofs, full_ofs;
  logic [8:0]  rb_data;
  logic        rb_sel;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ofs_seq_port uut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .prog_mode(prog_mode),
    .load_n(load_n), .wen1_n(wen1_n), .wr_data(wr_data),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .empty_ofs(empty_ofs),
    .full_ofs(full_ofs), .rb_data(rb_data), .rb_sel(rb_sel)
  );

  typedef struct packed {
    logic        ld_n;
    logic        we_n;
    logic [8:0]  d;
    logic [10:0] e;
    logic [10:0] f;
  } vec_t;

  // Write stimulus, with both offsets as they should read after settling.
  localparam vec_t VEC [7] = '{
    '{1'b0, 1'b0, 9'h1A5, 11'h0A5, 11'h007},  // R2 R5 empty-low, bit 8 ignored
    '{1'b0, 1'b1, 9'h0FF, 11'h0A5, 11'h007},  // R4 enable high, no write
    '{1'b0, 1'b0, 9'h1FE, 11'h6A5, 11'h007},  // R2 R5 empty-high takes bits 2:0
    '{1'b1, 1'b0, 9'h0CC, 11'h6A5, 11'h007},  // R4 load high, no write
    '{1'b0, 1'b0, 9'h033, 11'h6A5, 11'h033},  // R2 full-low
    '{1'b0, 1'b0, 9'h105, 11'h6A5, 11'h533},  // R2 full-high
    '{1'b0, 1'b0, 9'h011, 11'h611, 11'h533}   // R3 wrap to empty-low
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic idle();
    load_n = 1'b1; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
  endtask

  task automatic wr_edge(input logic [8:0] d);
    load_n = 1'b0; wen1_n = 1'b0; wr_data = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rb_edge();
    load_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge clk);
    idle();
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(); prog_mode = 1'b1; wr_data = '0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 empty_ofs", 16'(empty_ofs), 16'h007);
    check("R1 full_ofs", 16'(full_ofs), 16'h007);
    check("R1 rb_data", 16'(rb_data), 16'h000);
    check("R1 rb_sel", 16'(rb_sel), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      load_n = VEC[i].ld_n; wen1_n = VEC[i].we_n; wr_data = VEC[i].d;
      @(negedge clk);
      idle();
      settle();
      check("R2-R5 vector empty_ofs", 16'(empty_ofs), 16'(VEC[i].e));
      check("R2-R5 vector full_ofs", 16'(full_ofs), 16'(VEC[i].f));
    end

    // R6: readback in order, zero-extended.
    rb_edge(); check("R6 rb empty-low", 16'(rb_data), 16'h011);
    check("R10 rb_sel set", 16'(rb_sel), 16'h1);
    rb_edge(); check("R6 rb empty-high", 16'(rb_data), 16'h006);
    rb_edge(); check("R6 rb full-low", 16'(rb_data), 16'h033);
    rb_edge(); check("R6 rb full-high", 16'(rb_data), 16'h005);
    rb_edge(); check("R7 rb wrap", 16'(rb_data), 16'h011);

    // R10: an ordinary read clears rb_sel and keeps rb_data.
    ren1_n = 1'b0; ren2_n = 1'b0; @(negedge clk); idle();
    check("R10 rb_sel clear", 16'(rb_sel), 16'h0);
    check("R7 rb_data held", 16'(rb_data), 16'h011);
    rb_edge(); check("R7 rb continues", 16'(rb_data), 16'h006);

    // R7: one read enable high, so no step.
    load_n = 1'b0; ren1_n = 1'b0; @(negedge clk); idle();
    check("R7 partial enable data", 16'(rb_data), 16'h006);
    check("R10 rb_sel hold", 16'(rb_sel), 16'h1);
    rb_edge(); check("R7 no step", 16'(rb_data), 16'h033);

    // R8: mode off.
    prog_mode = 1'b0;
    wr_edge(9'h0FF); settle();
    check("R8 empty kept", 16'(empty_ofs), 16'h611);
    check("R8 full kept", 16'(full_ofs), 16'h533);
    rb_edge();
    check("R8 rb kept", 16'(rb_data), 16'h033);
    prog_mode = 1'b1;
    rb_edge(); check("R8 rd position kept", 16'(rb_data), 16'h005);
    wr_edge(9'h002); settle();
    check("R8 wr position kept", 16'(empty_ofs), 16'h211);

    // R9: latency of each offset.
    wr_edge(9'h044);
    check("R9 full next edge", 16'(full_ofs), 16'h544);
    wr_edge(9'h001);
    check("R9 full high", 16'(full_ofs), 16'h144);
    wr_edge(9'h077);
    @(negedge clk);
    check("R9 empty not yet", 16'(empty_ofs), 16'h211);
    @(negedge clk);
    check("R9 empty second edge", 16'(empty_ofs), 16'h277);

    // R1: mid-run reset.
    rb_edge();
    rst_n = 1'b0; @(negedge clk); @(negedge clk);
    check("R1 reset empty", 16'(empty_ofs), 16'h007);
    check("R1 reset full", 16'(full_ofs), 16'h007);
    check("R1 reset rb_data", 16'(rb_data), 16'h000);
    check("R1 reset rb_sel", 16'(rb_sel), 16'h0);
    rst_n = 1'b1; @(negedge clk);
    wr_edge(9'h0AA); settle();
    check("R1 wr position reset", 16'(empty_ofs), 16'h0AA);
    rb_edge();
    check("R1 rd position reset", 16'(rb_data), 16'h0AA);

    finish_run();
  end
endmodule